// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a byte-wide host bus and the internal program/erase sequencer of a flash array. The host writes command bytes. The decoder picks the source of the read path: the array, the identifier bytes, or the status word. It runs the two-write program and erase sequences, holds the target address and data for the sequencer, and pulses requests to start, resume or clear. It also tells the status logic when the host has written a bad command sequence.

Which command bytes are accepted depends on what the sequencer is doing. While a program runs, only the status-read command is obeyed. While an erase runs, a suspend request is also accepted. When the erase is paused, array reads and resume are accepted as well. The sequencer reports back with two single-cycle inputs: one for completion and one for reaching its pause point. The status word itself is stored outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, the read source is array (rd_src = 0), no request pulse is high, and suspend_req is low.
- R2: In the ready state, a write of FFh selects the array (rd_src = 0), 90h selects the identifier (rd_src = 1), and 70h selects status (rd_src = 2). A write of 50h gives a one-cycle clr_status pulse and leaves rd_src unchanged.
- R3: After 40h, the next write that is not FFh gives a one-cycle start_prog pulse. In that same cycle, op_addr and op_data hold that write's address and data, and rd_src = 2.
- R4: After 40h, writing FFh twice returns the read source to array with no start_prog. If FFh is followed by any other byte, a program starts with that byte as data.
- R5: After 20h, a write of D0h gives a one-cycle start_erase pulse, latches its address into op_addr, and selects status.
- R6: After 20h, any write other than D0h gives a one-cycle seq_err pulse (request to set both the program-error and erase-error bits), selects status, and starts nothing. The following write is decoded as in the ready state.
- R7: A D0h written in the ready state gives only a seq_err pulse. rd_src and the latches are unchanged.
- R8: While a program runs, every byte other than 70h is ignored: no pulse, no change of rd_src, suspend_req or the latches.
- R9: While an erase runs, only 70h and B0h are obeyed. B0h raises suspend_req. A D0h with no suspend pending is ignored.
- R10: After the sequencer reports it has paused, only FFh (array), 70h (status) and D0h are obeyed. D0h gives a one-cycle resume pulse, drops suspend_req and selects status. A D0h written before the pause is reported withdraws the request without a resume pulse.
- R11: A completion report from the sequencer returns the decoder to the ready state with rd_src = 2. rd_src stays at 2 until a read command is written.
- R12: B0h written at any time other than during an active erase is ignored.
- R13: id_byte is MFR_ID when rd_addr bit 0 is 0 and DEV_ID when it is 1. All other address bits are ignored.
- R14: Bytes that are not command codes (all but 20h, 40h, 50h, 70h, 90h, B0h, D0h, FFh), written in the ready state, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data / command byte |
| rd_addr | input | ADDR_W | Host read address (bit 0 used in identifier mode) |
| seq_done | input | 1 | Sequencer finished or aborted its operation (pulse) |
| seq_paused | input | 1 | Sequencer reached its erase pause point (pulse) |
| rd_src | output | 2 | Read path source: 0 array, 1 identifier, 2 status |
| id_byte | output | 8 | Identifier byte for the current read address |
| op_addr | output | ADDR_W | Latched program/erase address |
| op_data | output | 8 | Latched program data |
| start_prog | output | 1 | Start program request (pulse) |
| start_erase | output | 1 | Start erase request (pulse) |
| suspend_req | output | 1 | Erase suspend request (level) |
| resume | output | 1 | Erase resume request (pulse) |
| clr_status | output | 1 | Clear error status bits (pulse) |
| seq_err | output | 1 | Set program and erase error bits (pulse) |

## Verification
The hardest state to reach from the ports is the paused erase. Getting there takes a two-write erase start, a suspend byte, and then a pause report that the bench plays as the sequencer. After that, every byte value is swept while the decoder sits in that state. The bench checks that only the three accepted bytes have any effect. The same full 256-value sweep is run in the ready, program-running and erase-running states. The escape from program setup is driven along both of its branches.

// File: rtl/fcmd_pkg.sv
// Shared types for the flash command decoder.
// Holds the command byte values, the decoded command kinds, the read-path
// sources and the decoder modes.
package fcmd_pkg;

    localparam logic [7:0] C_ERASE_SETUP = 8'h20;
    localparam logic [7:0] C_PROG_SETUP  = 8'h40;
    localparam logic [7:0] C_CLEAR       = 8'h50;
    localparam logic [7:0] C_RSTAT       = 8'h70;
    localparam logic [7:0] C_IDENT       = 8'h90;
    localparam logic [7:0] C_SUSPEND     = 8'hB0;
    localparam logic [7:0] C_CONFIRM     = 8'hD0;
    localparam logic [7:0] C_RARRAY      = 8'hFF;

    typedef enum logic [3:0] {
        K_NONE, K_ERASE_SETUP, K_PROG_SETUP, K_CLEAR, K_RSTAT,
        K_IDENT, K_SUSPEND, K_CONFIRM, K_RARRAY
    } cmd_kind_t;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_IDENT  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_t;

    typedef enum logic [2:0] {
        M_READY, M_PSETUP, M_PESC, M_ESETUP,
        M_PRUN, M_ERUN, M_SWAIT, M_SUSP
    } mode_t;

endpackage

// File: rtl/fcmd_classify.sv
// Command byte classifier.
// Maps a written byte to a command kind. Purely combinational.
// Assumes: any byte that is not a listed code decodes to K_NONE.
module fcmd_classify
    import fcmd_pkg::*;
(
    input  logic [7:0] byte_in,
    output cmd_kind_t  kind
);

    // Purpose: table lookup of the command code.
    always_comb begin
        unique case (byte_in)
            C_ERASE_SETUP: kind = K_ERASE_SETUP;
            C_PROG_SETUP:  kind = K_PROG_SETUP;
            C_CLEAR:       kind = K_CLEAR;
            C_RSTAT:       kind = K_RSTAT;
            C_IDENT:       kind = K_IDENT;
            C_SUSPEND:     kind = K_SUSPEND;
            C_CONFIRM:     kind = K_CONFIRM;
            C_RARRAY:      kind = K_RARRAY;
            default:       kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/fcmd_fsm.sv
// Command sequencing state machine.
// Tracks setup, running and suspend modes, selects the read-path source,
// and issues the single-cycle requests to the sequencer and status logic.
// Assumes: seq_done and seq_paused are single-cycle pulses. A sequencer
// report takes priority over a host write in the same cycle, and that write
// is dropped.
module fcmd_fsm
    import fcmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  cmd_kind_t kind,
    input  logic      seq_done,
    input  logic      seq_paused,
    output rd_src_t   src,
    output logic      ld_prog,
    output logic      ld_erase,
    output logic      start_prog,
    output logic      start_erase,
    output logic      suspend_req,
    output logic      resume,
    output logic      clr_status,
    output logic      seq_err
);

    mode_t mode;
    logic  running;

    assign running = (mode == M_PRUN) || (mode == M_ERUN) ||
                     (mode == M_SWAIT) || (mode == M_SUSP);

    // Purpose: load strobes for the address/data latches on an accepted write.
    always_comb begin
        ld_prog  = wr_en && (mode == M_PSETUP || mode == M_PESC) && (kind != K_RARRAY);
        ld_erase = wr_en && (mode == M_ESETUP) && (kind == K_CONFIRM);
    end

    assign suspend_req = (mode == M_SWAIT) || (mode == M_SUSP);

    // Purpose: mode, read source and request pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode        <= M_READY;
            src         <= SRC_ARRAY;
            start_prog  <= 1'b0;
            start_erase <= 1'b0;
            resume      <= 1'b0;
            clr_status  <= 1'b0;
            seq_err     <= 1'b0;
        end else begin
            start_prog  <= 1'b0;
            start_erase <= 1'b0;
            resume      <= 1'b0;
            clr_status  <= 1'b0;
            seq_err     <= 1'b0;
            if (seq_done && running) begin
                mode <= M_READY;
                src  <= SRC_STATUS;
            end else if (seq_paused && mode == M_SWAIT) begin
                mode <= M_SUSP;
            end else if (wr_en) begin
                unique case (mode)
                    M_READY: begin
                        unique case (kind)
                            K_RARRAY:      src <= SRC_ARRAY;
                            K_IDENT:       src <= SRC_IDENT;
                            K_RSTAT:       src <= SRC_STATUS;
                            K_CLEAR:       clr_status <= 1'b1;
                            K_CONFIRM:     seq_err <= 1'b1;
                            K_PROG_SETUP: begin
                                mode <= M_PSETUP;
                                src  <= SRC_STATUS;
                            end
                            K_ERASE_SETUP: begin
                                mode <= M_ESETUP;
                                src  <= SRC_STATUS;
                            end
                            default: ;
                        endcase
                    end
                    M_PSETUP, M_PESC: begin
                        if (kind == K_RARRAY) begin
                            if (mode == M_PESC) begin
                                mode <= M_READY;
                                src  <= SRC_ARRAY;
                            end else begin
                                mode <= M_PESC;
                            end
                        end else begin
                            mode       <= M_PRUN;
                            start_prog <= 1'b1;
                        end
                    end
                    M_ESETUP: begin
                        src <= SRC_STATUS;
                        if (kind == K_CONFIRM) begin
                            mode        <= M_ERUN;
                            start_erase <= 1'b1;
                        end else begin
                            mode    <= M_READY;
                            seq_err <= 1'b1;
                        end
                    end
                    M_PRUN: begin
                        if (kind == K_RSTAT) src <= SRC_STATUS;
                    end
                    M_ERUN: begin
                        if (kind == K_RSTAT)   src  <= SRC_STATUS;
                        if (kind == K_SUSPEND) mode <= M_SWAIT;
                    end
                    M_SWAIT: begin
                        if (kind == K_RSTAT)   src  <= SRC_STATUS;
                        if (kind == K_CONFIRM) mode <= M_ERUN;
                    end
                    M_SUSP: begin
                        unique case (kind)
                            K_RARRAY: src <= SRC_ARRAY;
                            K_RSTAT:  src <= SRC_STATUS;
                            K_CONFIRM: begin
                                mode   <= M_ERUN;
                                src    <= SRC_STATUS;
                                resume <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    default: mode <= M_READY;
                endcase
            end
        end
    end

    // R3
    prog_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_prog |=> !start_prog);

    // R5
    erase_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_erase |-> ($past(mode) == M_ESETUP));

    // R9
    suspend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspend_req) |-> ($past(wr_en) && $past(kind) == K_SUSPEND));

    // R10
    resume_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> !suspend_req);

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_erase, resume, clr_status, seq_err}));

endmodule

// File: rtl/fcmd_latch.sv
// Operation address/data latch.
// Holds the target address and program data for the sequencer. An erase
// load takes the address only and keeps the data.
// Assumes: the two load strobes are never high in the same cycle.
module fcmd_latch #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_prog,
    input  logic              ld_erase,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);

    // Purpose: capture the address and data on an accepted program or erase write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr <= '0;
            op_data <= '0;
        end else if (ld_prog) begin
            op_addr <= addr_in;
            op_data <= data_in;
        end else if (ld_erase) begin
            op_addr <= addr_in;
        end
    end

    // R8
    no_dual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_prog && ld_erase));

endmodule

// File: rtl/fcmd_ident.sv
// Identifier byte selector.
// Returns the manufacturer or device code, chosen by read address bit 0 only.
module fcmd_ident #(
    parameter int         ADDR_W = 8,
    parameter logic [7:0] MFR_ID = 8'hA5,
    parameter logic [7:0] DEV_ID = 8'h3C
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        id_byte
);

    // Purpose: two-way select on the lowest address bit.
    always_comb begin
        id_byte = rd_addr[0] ? DEV_ID : MFR_ID;
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Flash command interface decoder, top level.
// Classifies host command bytes, sequences the two-write operations, latches
// the operand, and drives the read-path source and sequencer requests.
// Assumes: one host write per wr_en cycle, and sequencer reports as pulses.
module flash_cmd_decoder
    import fcmd_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter logic [7:0] MFR_ID = 8'hA5,
    parameter logic [7:0] DEV_ID = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              seq_done,
    input  logic              seq_paused,
    output logic [1:0]        rd_src,
    output logic [7:0]        id_byte,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              start_prog,
    output logic              start_erase,
    output logic              suspend_req,
    output logic              resume,
    output logic              clr_status,
    output logic              seq_err
);

    cmd_kind_t kind;
    rd_src_t   src;
    logic      ld_prog;
    logic      ld_erase;

    fcmd_classify u_classify (
        .byte_in (wr_data),
        .kind    (kind)
    );

    fcmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .kind        (kind),
        .seq_done    (seq_done),
        .seq_paused  (seq_paused),
        .src         (src),
        .ld_prog     (ld_prog),
        .ld_erase    (ld_erase),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .suspend_req (suspend_req),
        .resume      (resume),
        .clr_status  (clr_status),
        .seq_err     (seq_err)
    );

    fcmd_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_prog  (ld_prog),
        .ld_erase (ld_erase),
        .addr_in  (wr_addr),
        .data_in  (wr_data),
        .op_addr  (op_addr),
        .op_data  (op_data)
    );

    fcmd_ident #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_ident (
        .rd_addr (rd_addr),
        .id_byte (id_byte)
    );

    assign rd_src = src;

    // R3
    prog_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_prog |-> (op_data == $past(wr_data) && op_addr == $past(wr_addr)));

    // R5
    erase_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_erase |-> (op_addr == $past(wr_addr) && rd_src == 2'd2));

endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

    localparam int         AW  = 8;
    localparam logic [7:0] MFR = 8'hA5;
    localparam logic [7:0] DEV = 8'h3C;

    // pulse vector bit order: {start_prog, start_erase, resume, clr_status, seq_err}
    localparam logic [4:0] P_NONE  = 5'b00000;
    localparam logic [4:0] P_PROG  = 5'b10000;
    localparam logic [4:0] P_ERASE = 5'b01000;
    localparam logic [4:0] P_RES   = 5'b00100;
    localparam logic [4:0] P_CLR   = 5'b00010;
    localparam logic [4:0] P_ERR   = 5'b00001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          seq_done = 1'b0;
    logic          seq_paused = 1'b0;
    logic [1:0]    rd_src;
    logic [7:0]    id_byte;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;
    logic          start_prog, start_erase, suspend_req, resume, clr_status, seq_err;

    int checks = 0;
    int errors = 0;
    logic [4:0] pulses;

    flash_cmd_decoder #(.ADDR_W(AW), .MFR_ID(MFR), .DEV_ID(DEV)) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .seq_done(seq_done), .seq_paused(seq_paused),
        .rd_src(rd_src), .id_byte(id_byte), .op_addr(op_addr), .op_data(op_data),
        .start_prog(start_prog), .start_erase(start_erase), .suspend_req(suspend_req),
        .resume(resume), .clr_status(clr_status), .seq_err(seq_err)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One host write; outputs sampled at the falling edge after the capturing edge.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        pulses = {start_prog, start_erase, resume, clr_status, seq_err};
    endtask

    task automatic done_pulse();
        @(negedge clk); seq_done = 1'b1;
        @(negedge clk); seq_done = 1'b0;
    endtask

    task automatic pause_pulse();
        @(negedge clk); seq_paused = 1'b1;
        @(negedge clk); seq_paused = 1'b0;
    endtask

    function automatic logic is_cmd(input logic [7:0] c);
        return c == 8'h20 || c == 8'h40 || c == 8'h50 || c == 8'h70 ||
               c == 8'h90 || c == 8'hB0 || c == 8'hD0 || c == 8'hFF;
    endfunction

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] a0;
        logic [7:0]    d0;
        logic [1:0]    exp_src;
        logic [4:0]    exp_p;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_src", rd_src, 0);
        check("R1 pulses", {start_prog, start_erase, resume, clr_status, seq_err}, P_NONE);
        check("R1 suspend_req", suspend_req, 0);

        // R13 identifier: exhaustive sweep of read address
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            rd_addr = i[AW-1:0];
            #1;
            check("R13 id_byte", id_byte, i[0] ? DEV : MFR);
        end

        // R2 R7 R12 R14: every byte in the ready state
        for (int c = 0; c < 256; c++) begin
            wr(8'h00, 8'hFF);
            a0 = op_addr; d0 = op_data;
            wr(8'h5A, c[7:0]);
            exp_p = P_NONE;
            exp_src = 2'd0;
            if (c == 8'h90) exp_src = 2'd1;
            if (c == 8'h70 || c == 8'h40 || c == 8'h20) exp_src = 2'd2;
            if (c == 8'h50) exp_p = P_CLR;
            if (c == 8'hD0) exp_p = P_ERR;
            if (!is_cmd(c[7:0]))
                check("R14 unrecognised ignored", {rd_src, pulses, suspend_req}, {exp_src, exp_p, 1'b0});
            else if (c == 8'hB0)
                check("R12 suspend outside erase", {rd_src, pulses, suspend_req}, {exp_src, exp_p, 1'b0});
            else if (c == 8'hD0)
                check("R7 stray confirm", {rd_src, pulses}, {exp_src, exp_p});
            else
                check("R2 ready decode", {rd_src, pulses}, {exp_src, exp_p});
            check("R14 latches kept", {op_addr, op_data}, {a0, d0});
            if (c == 8'h40) begin wr(0, 8'hFF); wr(0, 8'hFF); end
            if (c == 8'h20) wr(0, 8'hFF);
        end

        // R3 program start with operand
        wr(8'h00, 8'hFF);
        wr(8'h11, 8'h40);
        check("R3 setup selects status", rd_src, 2);
        wr(8'h6B, 8'h96);
        check("R3 start pulse", pulses, P_PROG);
        check("R3 operand", {op_addr, op_data}, {8'h6B, 8'h96});
        // R8 every byte ignored while the program runs
        for (int c = 0; c < 256; c++) begin
            wr(c[7:0] ^ 8'h33, c[7:0]);
            check("R8 program busy", {rd_src, pulses, suspend_req}, {2'd2, P_NONE, 1'b0});
            check("R8 latches kept", {op_addr, op_data}, {8'h6B, 8'h96});
        end
        // R11 completion leaves status selected
        done_pulse();
        check("R11 done status", rd_src, 2);
        wr(0, 8'h5A);
        check("R11 status persists", rd_src, 2);
        wr(0, 8'hB0);
        check("R12 suspend in ready", {rd_src, pulses, suspend_req}, {2'd2, P_NONE, 1'b0});
        wr(0, 8'hFF);
        check("R11 read array after done", rd_src, 0);

        // R4 double FFh escape, and FFh followed by data
        wr(0, 8'h40);
        wr(8'h22, 8'hFF);
        check("R4 first FF no start", {rd_src, pulses}, {2'd2, P_NONE});
        wr(8'h23, 8'hFF);
        check("R4 second FF to array", {rd_src, pulses}, {2'd0, P_NONE});
        wr(0, 8'h40);
        wr(8'h24, 8'hFF);
        wr(8'h25, 8'h3C);
        check("R4 FF then data starts", pulses, P_PROG);
        check("R4 operand", {op_addr, op_data}, {8'h25, 8'h3C});
        done_pulse();

        // R6 bad erase sequence, next command obeyed
        wr(0, 8'hFF);
        wr(8'h40, 8'h20);
        wr(8'h41, 8'h90);
        check("R6 bad sequence", {rd_src, pulses}, {2'd2, P_ERR});
        wr(0, 8'h90);
        check("R6 next command obeyed", rd_src, 1);

        // R5 erase start
        wr(8'h80, 8'h20);
        wr(8'hC4, 8'hD0);
        check("R5 erase start", {rd_src, pulses}, {2'd2, P_ERASE});
        check("R5 block address", op_addr, 8'hC4);
        // R9 erase running: all but 70h/B0h ignored
        for (int c = 0; c < 256; c++) begin
            if (c == 8'hB0) continue;
            wr(8'h01, c[7:0]);
            check("R9 erase busy", {rd_src, pulses, suspend_req}, {2'd2, P_NONE, 1'b0});
        end
        check("R9 address kept", op_addr, 8'hC4);
        wr(0, 8'hB0);
        check("R9 suspend request", {suspend_req, pulses}, {1'b1, P_NONE});
        wr(0, 8'hFF);
        check("R10 array refused before pause", {rd_src, suspend_req}, {2'd2, 1'b1});
        pause_pulse();
        // R10 paused: sweep every byte that must be ignored
        for (int c = 0; c < 256; c++) begin
            if (c == 8'hFF || c == 8'h70 || c == 8'hD0) continue;
            wr(8'h02, c[7:0]);
            check("R10 paused ignore", {rd_src, pulses, suspend_req}, {2'd2, P_NONE, 1'b1});
        end
        wr(0, 8'hFF);
        check("R10 array in pause", {rd_src, suspend_req}, {2'd0, 1'b1});
        wr(0, 8'h70);
        check("R10 status in pause", rd_src, 2);
        wr(0, 8'hFF);
        wr(0, 8'hD0);
        check("R10 resume", {rd_src, pulses, suspend_req}, {2'd2, P_RES, 1'b0});
        wr(0, 8'hB0);
        wr(0, 8'hD0);
        check("R10 withdraw before pause", {pulses, suspend_req}, {P_NONE, 1'b0});
        done_pulse();
        check("R11 erase done", {rd_src, suspend_req}, {2'd2, 1'b0});
        check("R5 no late pulses", {start_prog, start_erase, resume, clr_status, seq_err}, P_NONE);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule